// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host reach a small PHY register space (8-bit offsets, 8-bit data) through just two halfword registers in its own address map. A command register holds the target PHY offset and a direction flag; a data register holds the byte to send or the byte returned. Writing the command register launches exactly one cycle on a simple request/acknowledge PHY port. A busy flag in the command register shows that the cycle is still running.

To write a PHY register, software first loads the data register. It then writes the command register with the write flag set and the offset, and polls until busy clears. To read, software writes the command register with the flag clear, polls until busy clears, and then reads the byte from the data register. The PHY side may take any number of cycles to acknowledge. The host read path is combinational from the block's state.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, busy is 0 and the latched offset, the write flag and the data register are all 0. The command register at host offset 0x300 and the data register at host offset 0x304 both read 0x0000.
- R2: A host read of the command register (0x300) returns the latched PHY offset in bits [7:0], the write flag in bit 8 (1 = write, 0 = read) and busy in bit 9. Bits [15:10] read 0.
- R3: A host write to 0x300 while not busy is accepted. In the next cycle busy reads 1 and p_req is 1. p_addr equals bits [7:0] of the written word, and p_we equals bit 8 of the written word.
- R4: During a write transfer, p_wdata carries the low byte of the data register. p_req, p_we, p_addr and p_wdata stay unchanged until the cycle in which p_ack is sampled high.
- R5: When p_ack is sampled high while busy, busy and p_req are 0 from the next cycle. With an acknowledge after L waiting cycles, busy reads 1 in exactly L+1 consecutive cycles. Each command produces exactly one acknowledged PHY cycle.
- R6: For a read transfer, the byte on p_rdata is captured into the data register at the same clock edge where busy falls. Software reads it at 0x304 as {8'h00, byte}.
- R7: On a host write to 0x304 only bits [7:0] are stored; bits [15:8] are ignored and always read back as 0.
- R8: While busy, a host write to 0x300 is ignored: the transfer in flight keeps its offset and direction, and no second transfer follows. A host write to 0x304 is also ignored while busy.
- R9: Host writes to any address other than 0x300 and 0x304 change nothing, and host reads of such addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | Host access is a write when 1 |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | 16 | Host write halfword |
| h_rdata | output | 16 | Host read halfword (combinational) |
| p_req | output | 1 | PHY cycle request, high while busy |
| p_we | output | 1 | PHY cycle is a write |
| p_addr | output | 8 | PHY register offset |
| p_wdata | output | 8 | PHY write byte |
| p_rdata | input | 8 | PHY read byte, valid with p_ack |
| p_ack | input | 1 | PHY acknowledge, one cycle |

## Verification
The hardest situation to reach is a host write that lands while a PHY cycle is still outstanding. With a quick PHY, the window closes before software can write again. The bench's PHY responder therefore takes a programmable latency. Long latencies are used to open a wide window, and inside it the bench writes a conflicting command and new data. It then checks at the PHY pins and in the memory model that the transfer in flight was undisturbed and that only one acknowledge occurred. The full sweeps over all 256 offsets rotate the latency from zero upward, so that the zero-wait acknowledge and the busy-length arithmetic are covered too.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

  typedef enum logic [1:0] {
    HSEL_NONE = 2'd0,
    HSEL_CMD  = 2'd1,
    HSEL_DATA = 2'd2
  } hsel_e;

  // Build the command-register read word: offset, direction flag, busy.
  function automatic logic [31:0] pack_cmd(input logic [31:0] off,
                                           input logic wr,
                                           input logic busy,
                                           input int unsigned aw);
    logic [31:0] m;
    m = (32'd1 << aw) - 32'd1;
    return (off & m) | (32'(wr) << aw) | (32'(busy) << (aw + 1));
  endfunction

  // Data-register read word: only the PHY byte, upper bits zero.
  function automatic logic [31:0] pack_data(input logic [31:0] d,
                                            input int unsigned dw);
    return d & ((32'd1 << dw) - 32'd1);
  endfunction

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode #(
  parameter int unsigned          HOST_AW  = 12,
  parameter logic [HOST_AW-1:0]   CMD_ADR  = 12'h300,
  parameter logic [HOST_AW-1:0]   DATA_ADR = 12'h304
) (
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HOST_AW-1:0] h_addr,
  output phy_bridge_pkg::hsel_e rsel,
  output logic               cmd_we,
  output logic               data_we
);
  import phy_bridge_pkg::*;

  always_comb begin
    rsel = HSEL_NONE;
    if (h_addr == CMD_ADR)       rsel = HSEL_CMD;
    else if (h_addr == DATA_ADR) rsel = HSEL_DATA;
  end

  assign cmd_we  = h_sel && h_wr && (rsel == HSEL_CMD);
  assign data_we = h_sel && h_wr && (rsel == HSEL_DATA);
endmodule

// File: rtl/bridge_xfer.sv
module bridge_xfer #(
  parameter int unsigned PHY_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [PHY_AW-1:0] cmd_off,
  input  logic              cmd_wr,
  input  logic              p_ack,
  output logic              busy,
  output logic [PHY_AW-1:0] off_q,
  output logic              wr_q,
  output logic              accept,
  output logic              done
);
  assign accept = cmd_we && !busy;
  assign done   = busy && p_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      off_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      off_q <= cmd_off;
      wr_q  <= cmd_wr;
    end else if (done) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_datareg.sv
module bridge_datareg #(
  parameter int unsigned PHY_DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [PHY_DW-1:0] host_byte,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [PHY_DW-1:0] cap_byte,
  output logic [PHY_DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                q <= '0;
    else if (cap_en)           q <= cap_byte;
    else if (host_we && !busy) q <= host_byte;
  end
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int unsigned        HOST_AW  = 12,
  parameter int unsigned        HOST_DW  = 16,
  parameter int unsigned        PHY_AW   = 8,
  parameter int unsigned        PHY_DW   = 8,
  parameter logic [HOST_AW-1:0] CMD_ADR  = 12'h300,
  parameter logic [HOST_AW-1:0] DATA_ADR = 12'h304
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HOST_AW-1:0] h_addr,
  input  logic [HOST_DW-1:0] h_wdata,
  output logic [HOST_DW-1:0] h_rdata,
  output logic               p_req,
  output logic               p_we,
  output logic [PHY_AW-1:0]  p_addr,
  output logic [PHY_DW-1:0]  p_wdata,
  input  logic [PHY_DW-1:0]  p_rdata,
  input  logic               p_ack
);
  import phy_bridge_pkg::*;

  localparam int unsigned WR_POS = PHY_AW;

  hsel_e             rsel;
  logic              cmd_we, data_we;
  logic              busy, wr_q, accept, done, cap_en;
  logic [PHY_AW-1:0] off_q;
  logic [PHY_DW-1:0] data_q;
  logic [31:0]       cmd_word, data_word;

  bridge_decode #(.HOST_AW(HOST_AW), .CMD_ADR(CMD_ADR), .DATA_ADR(DATA_ADR)) u_dec (
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .rsel(rsel), .cmd_we(cmd_we), .data_we(data_we)
  );

  bridge_xfer #(.PHY_AW(PHY_AW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
    .cmd_off(h_wdata[PHY_AW-1:0]), .cmd_wr(h_wdata[WR_POS]),
    .p_ack(p_ack), .busy(busy), .off_q(off_q), .wr_q(wr_q),
    .accept(accept), .done(done)
  );

  assign cap_en = done && !wr_q;

  bridge_datareg #(.PHY_DW(PHY_DW)) u_data (
    .clk(clk), .rst_n(rst_n), .host_we(data_we),
    .host_byte(h_wdata[PHY_DW-1:0]), .busy(busy),
    .cap_en(cap_en), .cap_byte(p_rdata), .q(data_q)
  );

  assign cmd_word  = pack_cmd(32'(off_q), wr_q, busy, PHY_AW);
  assign data_word = pack_data(32'(data_q), PHY_DW);

  always_comb begin
    h_rdata = '0;
    if (h_sel && !h_wr) begin
      case (rsel)
        HSEL_CMD:  h_rdata = cmd_word[HOST_DW-1:0];
        HSEL_DATA: h_rdata = data_word[HOST_DW-1:0];
        default:   h_rdata = '0;
      endcase
    end
  end

  assign p_req   = busy;
  assign p_we    = busy && wr_q;
  assign p_addr  = off_q;
  assign p_wdata = data_q;
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int unsigned PHY_AW = 8,
  parameter int unsigned PHY_DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              cmd_we,
  input logic              busy,
  input logic              p_req,
  input logic              p_we,
  input logic              p_ack,
  input logic [PHY_AW-1:0] p_addr,
  input logic [PHY_DW-1:0] p_wdata,
  input logic [PHY_DW-1:0] p_rdata,
  input logic [PHY_DW-1:0] data_q
);
  // R3
  a_r3_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && p_req));

  // R4
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && !p_ack) |=> (p_req && $stable(p_addr) && $stable(p_we) && $stable(p_wdata)));

  // R5
  a_r5_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && p_ack) |=> (!busy && !p_req));

  // R6
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && p_ack && !p_we) |=> (data_q == $past(p_rdata)));

  // R8
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && p_req && !p_ack) |=> ($stable(p_addr) && $stable(p_we)));
endmodule

bind phy_reg_bridge bridge_chk #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_we(cmd_we), .busy(busy),
  .p_req(p_req), .p_we(p_we), .p_ack(p_ack), .p_addr(p_addr),
  .p_wdata(p_wdata), .p_rdata(p_rdata), .data_q(data_q)
);

// File: tb/tb_phy_reg_bridge.sv
`timescale 1ns/1ps
module tb_phy_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_sel = 1'b0, h_wr = 1'b0;
  logic [11:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        p_req, p_we, p_ack = 1'b0;
  logic [7:0]  p_addr, p_wdata, p_rdata = '0;

  int total = 0, bad = 0;
  int lat = 0, cnt = 0, acks = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  phy_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .p_req(p_req), .p_we(p_we),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_ack(p_ack)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction

  // PHY responder: acknowledges after lat waiting cycles.
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ack = 1'b0; cnt = 0;
    end else if (p_ack) begin
      p_ack = 1'b0; cnt = 0;
    end else if (p_req) begin
      if (cnt >= lat) begin
        p_ack = 1'b1; acks = acks + 1;
        p_rdata = mem[p_addr];
        if (p_we) mem[p_addr] = p_wdata;
      end else cnt = cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_sel = 1'b0; h_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [15:0] d);
    h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
    #1 d = h_rdata;
    h_sel = 1'b0;
  endtask

  // Called right after a command write; counts cycles with busy set.
  task automatic wait_idle(output int ncyc);
    logic [15:0] v;
    ncyc = 0;
    hread(12'h300, v);
    while (v[9]) begin
      ncyc++;
      @(negedge clk);
      hread(12'h300, v);
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, a0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(12'h300, v); chk("R1 cmd", v, 16'h0000);
    hread(12'h304, v); chk("R1 data", v, 16'h0000);
    chk("R1 req", p_req, 0);

    // R3/R2 launch timing and readback, R5 busy length
    lat = 3;
    hwrite(12'h304, 16'h00C4);
    hwrite(12'h300, 16'hFD5A);      // write flag, offset 0x5A, junk upper bits
    chk("R3 req", p_req, 1);
    chk("R3 addr", p_addr, 8'h5A);
    chk("R3 we", p_we, 1);
    chk("R4 wdata", p_wdata, 8'hC4);
    hread(12'h300, v); chk("R2 cmd busy", v, 16'h035A);
    a0 = acks;
    wait_idle(n);
    chk("R5 busy cycles", n, 4);
    chk("R5 one ack", acks - a0, 1);
    chk("R5 req low", p_req, 0);
    hread(12'h300, v); chk("R2 cmd idle", v, 16'h015A);
    chk("R4 mem", mem[8'h5A], 8'hC4);

    // R7 upper data bits dropped
    hwrite(12'h304, 16'hAB3C);
    hread(12'h304, v); chk("R7 data", v, 16'h003C);

    // R9 other addresses
    hwrite(12'h308, 16'hFFFF);
    hwrite(12'h302, 16'h1234);
    hread(12'h308, v); chk("R9 read", v, 16'h0000);
    hread(12'h300, v); chk("R9 cmd kept", v, 16'h015A);
    hread(12'h304, v); chk("R9 data kept", v, 16'h003C);
    chk("R9 no req", p_req, 0);

    // Full write sweep, latency rotating 0..4
    for (int o = 0; o < 256; o++) begin
      lat = o % 5;
      hwrite(12'h304, 16'(16'hA500 | 16'((o * 13 + 1) & 8'hFF)));
      hwrite(12'h300, 16'(16'h0100 | o));
      a0 = acks;
      wait_idle(n);
      chk("R5 sweep busy", n, lat + 1);
      chk("R5 sweep ack", acks - a0, 1);
      chk("R4 sweep mem", mem[o], 8'((o * 13 + 1) & 8'hFF));
    end

    // Full read sweep (memory now holds o*13+1); R6
    for (int o = 0; o < 256; o++) begin
      lat = (o * 3) % 7;
      mem[o] = pat(o);
      hwrite(12'h300, 16'(o));
      chk("R3 sweep rd we", p_we, 0);
      wait_idle(n);
      hread(12'h304, v);
      chk("R6 sweep data", v, 16'(pat(o)));
      hread(12'h300, v);
      chk("R2 sweep cmd", v, 16'(o));
    end

    // R8: conflicting command and data writes during a long read
    lat = 20;
    hwrite(12'h300, 16'h0010);
    a0 = acks;
    hwrite(12'h300, 16'h0120);
    hwrite(12'h304, 16'h0077);
    chk("R8 addr kept", p_addr, 8'h10);
    chk("R8 we kept", p_we, 0);
    wait_idle(n);
    repeat (25) @(negedge clk);
    chk("R8 single ack", acks - a0, 1);
    chk("R8 no write", mem[8'h20], pat(8'h20));
    hread(12'h304, v); chk("R8 read data", v, 16'(pat(8'h10)));
    chk("R8 idle", p_req, 0);

    // R8: data write during a long PHY write does not alter it
    lat = 10;
    hwrite(12'h304, 16'h0011);
    hwrite(12'h300, 16'h0133);
    hwrite(12'h304, 16'h0099);
    chk("R8 wdata kept", p_wdata, 8'h11);
    wait_idle(n);
    chk("R8 mem written", mem[8'h33], 8'h11);
    hread(12'h304, v); chk("R8 data kept", v, 16'h0011);

    // R1 reset after activity
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hread(12'h300, v); chk("R1 cmd after", v, 16'h0000);
    hread(12'h304, v); chk("R1 data after", v, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule